// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel LCD output from a single pixel clock. A horizontal phase sequencer walks each line through active pixels, front porch, sync and back porch. A vertical phase sequencer, advanced once per line, walks each frame through active lines, front porch, sync and back porch. The block drives a line clock (`hsync`), a frame clock (`vsync`), a data-enable, pixel and line position counters and a field flag.

Three modes are selectable. The direct LCD mode produces separate sync pulses. The two embedded-sync modes are progressive and interlaced. In these modes the same porch and sync registers are reused as blanking lengths, and the two sync pins carry horizontal and vertical blanking indicators instead of pulses.

Timing configuration is latched into shadow registers during reset and at every frame or field boundary. Software may therefore rewrite the inputs at any time without tearing the current frame.

Top module: `lcd_raster_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `hPos` and `vPos` are 0, `fieldFlag` is 0, `de` is 1, and both sync pins sit at their inactive level. This places the raster on the first active pixel of a frame.
- R2: In the direct LCD mode (`cfgMode` 0), a line consists of `cfgActW` active pixels, then `cfgHfp` front-porch pixels, then an `hsync` pulse of (`cfgHsw[7:0]`+1) pixels, then `cfgHbp` back-porch pixels. Bits above bit 7 of `cfgHsw` are ignored in this mode. `hPos` counts 0 up to the line length minus one.
- R3: In the direct LCD mode, a frame consists of `cfgActH` active lines, then `cfgVfp` lines, then a `vsync` pulse of (`cfgVsw`+1) lines, then `cfgVbp` lines. `vPos` counts lines from 0 and changes only when `hPos` is 0.
- R4: `de` is 1 exactly when both the horizontal and the vertical positions lie in their active regions. While `de` is 1, both sync pins are inactive.
- R5: A porch or blanking count of 0 inserts no cycles or lines at all.
- R6: In embedded-sync progressive mode (`cfgMode` 1), each line has `cfgActW` active pixels followed by (`cfgHsw`+1) blanking pixels, using all 12 bits of `cfgHsw`, with `hsync` active over the blanking. The horizontal porch registers and `cfgVsw` are ignored. After `cfgActH` active lines come `cfgVfp` and then `cfgVbp` blanking lines, with `vsync` active over both.
- R7: In interlaced mode (`cfgMode` 2), `fieldFlag` toggles at every field boundary, starting at 0 after reset. Field 0 ends with `cfgHfp` then `cfgHbp` blanking lines. Field 1 ends with `cfgVfp` then `cfgVbp` blanking lines. Line timing is as in R6.
- R8: All size, porch, sync and mode inputs are sampled during reset and in the last cycle of each frame or field. A change made mid-frame takes effect at the next frame boundary.
- R9: `cfgHsPol` and `cfgVsPol` invert `hsync` and `vsync` respectively, with immediate effect. A value of 0 means active-high.
- R10: `cfgMode` 3 behaves as mode 0. Outside interlaced mode, `fieldFlag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgActW | input | 12 | Active pixels per line |
| cfgActH | input | 12 | Active lines per frame or field |
| cfgHfp | input | 12 | Horizontal front porch; even-field blanking count 1 when interlaced |
| cfgHbp | input | 12 | Horizontal back porch; even-field blanking count 2 when interlaced |
| cfgHsw | input | 12 | Sync width minus one (LCD, low 8 bits) or blanking length minus one (embedded modes) |
| cfgVfp | input | 12 | Vertical front porch; odd-field or frame blanking count 1 |
| cfgVbp | input | 12 | Vertical back porch; odd-field or frame blanking count 2 |
| cfgVsw | input | 8 | Vertical sync width minus one (LCD mode only) |
| cfgMode | input | 2 | 0 LCD, 1 embedded progressive, 2 embedded interlaced, 3 as 0 |
| cfgHsPol | input | 1 | Invert `hsync` when 1 |
| cfgVsPol | input | 1 | Invert `vsync` when 1 |
| hsync | output | 1 | Line clock or horizontal blanking indicator |
| vsync | output | 1 | Frame clock or vertical blanking indicator |
| de | output | 1 | Data enable |
| hPos | output | 15 | Pixel position within the line |
| vPos | output | 15 | Line position within the frame or field |
| fieldFlag | output | 1 | Current interlaced field |

## Verification
The hardest situation to reach is a configuration change landing inside a frame. It must not disturb the remaining lines of that frame, and it must then apply cleanly from the very next frame. The bench rewrites widths, porches and polarity partway through the first frame and compares every following cycle with a model that samples its own configuration copy only at field starts. Zero-length porches and the interlaced alternation of blanking pairs are also covered, by sweeping every cycle of several complete fields under each small configuration.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;
  localparam int NPH = 4;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_e;

  localparam logic [1:0] MD_LCD = 2'd0;
  localparam logic [1:0] MD_BTP = 2'd1;
  localparam logic [1:0] MD_BTI = 2'd2;

  typedef struct packed {
    logic lineEnd;
    logic fieldEnd;
    logic hActive;
    logic hSync;
    logic vActive;
    logic vSync;
    logic vBlank;
  } strobe_t;
endpackage

// File: rtl/lcdt_seq.sv
`timescale 1ns/1ps
module lcdt_seq
  import lcdt_pkg::*;
#(
  parameter int LW = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [NPH-1:0][LW-1:0]  len,
  output phase_e                  phase,
  output logic                    wrap
);
  logic [LW-1:0] cnt;
  logic          last;
  phase_e        nxt;
  logic          found;
  logic [1:0]    cand;

  always_comb begin
    nxt   = phase;
    found = 1'b0;
    cand  = 2'd0;
    for (int k = 1; k < NPH; k++) begin
      cand = 2'(phase) + 2'(k);
      if (!found && len[cand] != '0) begin
        nxt   = phase_e'(cand);
        found = 1'b1;
      end
    end
  end

  assign last = (cnt == len[phase] - LW'(1));
  assign wrap = adv && last && (nxt == PH_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ACT;
      cnt   <= '0;
    end else if (adv) begin
      if (last) begin
        phase <= nxt;
        cnt   <= '0;
      end else begin
        cnt <= cnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/lcdt_ctrl.sv
`timescale 1ns/1ps
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int LW = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPH-1:0][LW-1:0]  hLen,
  input  logic [NPH-1:0][LW-1:0]  vLen,
  output strobe_t                 stb
);
  phase_e hPh;
  phase_e vPh;
  logic   hWrap;
  logic   vWrap;

  lcdt_seq #(.LW(LW)) hSeq_i (
    .clk(clk), .rst(rst), .adv(1'b1), .len(hLen), .phase(hPh), .wrap(hWrap)
  );

  lcdt_seq #(.LW(LW)) vSeq_i (
    .clk(clk), .rst(rst), .adv(hWrap), .len(vLen), .phase(vPh), .wrap(vWrap)
  );

  always_comb begin
    stb.lineEnd  = hWrap;
    stb.fieldEnd = hWrap && vWrap;
    stb.hActive  = (hPh == PH_ACT);
    stb.hSync    = (hPh == PH_SYNC);
    stb.vActive  = (vPh == PH_ACT);
    stb.vSync    = (vPh == PH_SYNC);
    stb.vBlank   = (vPh != PH_ACT);
  end
endmodule

// File: rtl/lcdt_dp.sv
`timescale 1ns/1ps
module lcdt_dp
  import lcdt_pkg::*;
#(
  parameter int CW = 12,
  parameter int SW = 8,
  parameter int PW = CW + 3,
  localparam int LW = CW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 stb,
  input  logic [CW-1:0]           cfgActW,
  input  logic [CW-1:0]           cfgActH,
  input  logic [CW-1:0]           cfgHfp,
  input  logic [CW-1:0]           cfgHbp,
  input  logic [CW-1:0]           cfgHsw,
  input  logic [CW-1:0]           cfgVfp,
  input  logic [CW-1:0]           cfgVbp,
  input  logic [SW-1:0]           cfgVsw,
  input  logic [1:0]              cfgMode,
  input  logic                    cfgHsPol,
  input  logic                    cfgVsPol,
  output logic [NPH-1:0][LW-1:0]  hLen,
  output logic [NPH-1:0][LW-1:0]  vLen,
  output logic                    hsync,
  output logic                    vsync,
  output logic                    de,
  output logic [PW-1:0]           hPos,
  output logic [PW-1:0]           vPos,
  output logic                    fieldFlag
);
  logic [CW-1:0] shActW, shActH, shHfp, shHbp, shHsw, shVfp, shVbp;
  logic [SW-1:0] shVsw;
  logic [1:0]    shMode;
  logic          btMode;
  logic          interMode;
  logic [CW-1:0] blank1, blank2;

  always_ff @(posedge clk) begin
    if (rst || stb.fieldEnd) begin
      shActW <= cfgActW;
      shActH <= cfgActH;
      shHfp  <= cfgHfp;
      shHbp  <= cfgHbp;
      shHsw  <= cfgHsw;
      shVfp  <= cfgVfp;
      shVbp  <= cfgVbp;
      shVsw  <= cfgVsw;
      shMode <= cfgMode;
    end
  end

  assign btMode    = (shMode == MD_BTP) || (shMode == MD_BTI);
  assign interMode = (shMode == MD_BTI);

  always_comb begin
    if (interMode && !fieldFlag) begin
      blank1 = shHfp;
      blank2 = shHbp;
    end else begin
      blank1 = shVfp;
      blank2 = shVbp;
    end
  end

  always_comb begin
    hLen[PH_ACT] = LW'(shActW);
    vLen[PH_ACT] = LW'(shActH);
    vLen[PH_FP]  = LW'(blank1);
    vLen[PH_BP]  = LW'(blank2);
    if (btMode) begin
      hLen[PH_FP]   = '0;
      hLen[PH_SYNC] = LW'(shHsw) + LW'(1);
      hLen[PH_BP]   = '0;
      vLen[PH_SYNC] = '0;
    end else begin
      hLen[PH_FP]   = LW'(shHfp);
      hLen[PH_SYNC] = LW'(shHsw[SW-1:0]) + LW'(1);
      hLen[PH_BP]   = LW'(shHbp);
      vLen[PH_SYNC] = LW'(shVsw) + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hPos      <= '0;
      vPos      <= '0;
      fieldFlag <= 1'b0;
    end else begin
      hPos <= stb.lineEnd ? '0 : hPos + PW'(1);
      if (stb.fieldEnd) begin
        vPos      <= '0;
        fieldFlag <= (cfgMode == MD_BTI) ? ~fieldFlag : 1'b0;
      end else if (stb.lineEnd) begin
        vPos <= vPos + PW'(1);
      end
    end
  end

  assign hsync = stb.hSync ^ cfgHsPol;
  assign vsync = (btMode ? stb.vBlank : stb.vSync) ^ cfgVsPol;
  assign de    = stb.hActive && stb.vActive;
endmodule

// File: rtl/lcd_raster_gen.sv
`timescale 1ns/1ps
module lcd_raster_gen
  import lcdt_pkg::*;
#(
  parameter int CW = 12,
  parameter int SW = 8,
  localparam int LW = CW + 1,
  localparam int PW = CW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfgActW,
  input  logic [CW-1:0] cfgActH,
  input  logic [CW-1:0] cfgHfp,
  input  logic [CW-1:0] cfgHbp,
  input  logic [CW-1:0] cfgHsw,
  input  logic [CW-1:0] cfgVfp,
  input  logic [CW-1:0] cfgVbp,
  input  logic [SW-1:0] cfgVsw,
  input  logic [1:0]    cfgMode,
  input  logic          cfgHsPol,
  input  logic          cfgVsPol,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [PW-1:0] hPos,
  output logic [PW-1:0] vPos,
  output logic          fieldFlag
);
  strobe_t                stb;
  logic [NPH-1:0][LW-1:0] hLen;
  logic [NPH-1:0][LW-1:0] vLen;

  lcdt_ctrl #(.LW(LW)) ctrl_i (
    .clk(clk), .rst(rst), .hLen(hLen), .vLen(vLen), .stb(stb)
  );

  lcdt_dp #(.CW(CW), .SW(SW), .PW(PW)) dp_i (
    .clk(clk), .rst(rst), .stb(stb),
    .cfgActW(cfgActW), .cfgActH(cfgActH), .cfgHfp(cfgHfp), .cfgHbp(cfgHbp),
    .cfgHsw(cfgHsw), .cfgVfp(cfgVfp), .cfgVbp(cfgVbp), .cfgVsw(cfgVsw),
    .cfgMode(cfgMode), .cfgHsPol(cfgHsPol), .cfgVsPol(cfgVsPol),
    .hLen(hLen), .vLen(vLen),
    .hsync(hsync), .vsync(vsync), .de(de), .hPos(hPos), .vPos(vPos),
    .fieldFlag(fieldFlag)
  );
endmodule

// File: rtl/lcd_raster_gen_chk.sv
`timescale 1ns/1ps
module lcd_raster_gen_chk #(
  parameter int PW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          fieldFlag,
  input logic          cfgHsPol,
  input logic          cfgVsPol,
  input logic [PW-1:0] hPos,
  input logic [PW-1:0] vPos
);
  a_r1_reset_origin: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hPos == '0 && vPos == '0 && !fieldFlag));

  a_r2_hpos_steps: assert property (@(posedge clk) disable iff (rst)
    (hPos != '0) |-> (hPos == PW'($past(hPos) + 1'b1)));

  a_r3_vpos_line_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(vPos) |-> (hPos == '0));

  a_r4_de_no_sync: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync == cfgHsPol && vsync == cfgVsPol));

  a_r7_field_at_origin: assert property (@(posedge clk) disable iff (rst)
    !$stable(fieldFlag) |-> (hPos == '0 && vPos == '0));
endmodule

bind lcd_raster_gen lcd_raster_gen_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
  .fieldFlag(fieldFlag), .cfgHsPol(cfgHsPol), .cfgVsPol(cfgVsPol),
  .hPos(hPos), .vPos(vPos)
);

// File: tb/lcd_raster_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_raster_gen_tb_top;
  localparam int CW = 12;
  localparam int SW = 8;
  localparam int PW = CW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfgActW, cfgActH, cfgHfp, cfgHbp, cfgHsw, cfgVfp, cfgVbp;
  logic [SW-1:0] cfgVsw;
  logic [1:0]    cfgMode;
  logic          cfgHsPol, cfgVsPol;
  logic          hsync, vsync, de, fieldFlag;
  logic [PW-1:0] hPos, vPos;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  int mActW, mActH, mHfp, mHbp, mHsw, mVfp, mVbp, mVsw, mMode;

  always #2 clk = ~clk;

  lcd_raster_gen dut_i (
    .clk(clk), .rst(rst), .cfgActW(cfgActW), .cfgActH(cfgActH),
    .cfgHfp(cfgHfp), .cfgHbp(cfgHbp), .cfgHsw(cfgHsw), .cfgVfp(cfgVfp),
    .cfgVbp(cfgVbp), .cfgVsw(cfgVsw), .cfgMode(cfgMode),
    .cfgHsPol(cfgHsPol), .cfgVsPol(cfgVsPol), .hsync(hsync), .vsync(vsync),
    .de(de), .hPos(hPos), .vPos(vPos), .fieldFlag(fieldFlag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int aw, input int ah, input int hf, input int hb, input int hs,
                        input int vf, input int vb, input int vs, input int md,
                        input bit hp, input bit vp);
    cfgActW = CW'(aw); cfgActH = CW'(ah); cfgHfp = CW'(hf); cfgHbp = CW'(hb);
    cfgHsw = CW'(hs); cfgVfp = CW'(vf); cfgVbp = CW'(vb); cfgVsw = SW'(vs);
    cfgMode = md[1:0]; cfgHsPol = hp; cfgVsPol = vp;
  endtask

  task automatic capture();
    mActW = cfgActW; mActH = cfgActH; mHfp = cfgHfp; mHbp = cfgHbp; mHsw = cfgHsw;
    mVfp = cfgVfp; mVbp = cfgVbp; mVsw = cfgVsw; mMode = cfgMode;
  endtask

  // reset with reset-state checks (R1)
  task automatic startRun();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "hPos in reset", hPos, 0);
    chk("R1", "vPos in reset", vPos, 0);
    chk("R1", "fieldFlag in reset", fieldFlag, 0);
    chk("R1", "de in reset", de, 1);
    chk("R1", "hsync in reset", hsync, cfgHsPol);
    chk("R1", "vsync in reset", vsync, cfgVsPol);
    rst = 1'b0;
  endtask

  task automatic runFields(input int nFields, input bit midChange, input string tag);
    for (int f = 0; f < nFields; f++) begin
      int hA, hF, hS, hB, lineLen, vA, b1, s, b2, frameLen, par;
      bit bt;
      capture();
      bt  = (mMode == 1) || (mMode == 2);
      par = (mMode == 2) ? (f % 2) : 0;
      hA = mActW;
      if (bt) begin hF = 0; hS = mHsw + 1; hB = 0; end
      else    begin hF = mHfp; hS = (mHsw % 256) + 1; hB = mHbp; end
      lineLen = hA + hF + hS + hB;
      vA = mActH;
      if (!bt)            begin b1 = mVfp; s = mVsw + 1; b2 = mVbp; end
      else if (mMode == 2 && par == 0) begin b1 = mHfp; s = 0; b2 = mHbp; end
      else                begin b1 = mVfp; s = 0; b2 = mVbp; end
      frameLen = vA + b1 + s + b2;
      for (int y = 0; y < frameLen; y++) begin
        for (int x = 0; x < lineLen; x++) begin
          int eh, ev, ed;
          eh = ((x >= hA + hF) && (x < hA + hF + hS)) ? 1 : 0;
          if (bt) ev = (y >= vA) ? 1 : 0;
          else    ev = ((y >= vA + b1) && (y < vA + b1 + s)) ? 1 : 0;
          ed = (x < hA && y < vA) ? 1 : 0;
          chk({tag, " R4"}, "de", de, ed);
          chk({tag, " R9"}, "hsync", hsync, eh ^ int'(cfgHsPol));
          chk({tag, " R9"}, "vsync", vsync, ev ^ int'(cfgVsPol));
          chk({tag, " R2"}, "hPos", hPos, x);
          chk({tag, " R3"}, "vPos", vPos, y);
          chk({tag, " R10"}, "fieldFlag", fieldFlag, par);
          if (midChange && f == 0 && y == 1 && x == 0) begin
            // R8: new sizes wait for the frame boundary; R9: polarity is immediate
            cfgActW = CW'(4); cfgHbp = CW'(0); cfgVfp = CW'(2); cfgHsPol = 1'b1;
          end
          @(negedge clk);
        end
      end
    end
  endtask

  initial begin
    // R2 R3 R4: basic direct LCD timing
    setCfg(3, 2, 1, 2, 1, 1, 1, 0, 0, 0, 0);
    startRun();
    runFields(3, 0, "R2_R3");
    // R5: all porches zero; R2: bits above 7 of sync width ignored (0x103 -> 4)
    setCfg(2, 2, 0, 0, 'h103, 0, 0, 2, 0, 0, 0);
    startRun();
    runFields(2, 0, "R5_R2");
    // R9 R10: inverted polarity in mode 3
    setCfg(2, 3, 2, 1, 0, 1, 2, 1, 3, 1, 1);
    startRun();
    runFields(2, 0, "R9_R10");
    // R6: embedded progressive, horizontal porches and vertical sync width ignored
    setCfg(3, 2, 5, 6, 2, 1, 2, 7, 1, 0, 0);
    startRun();
    runFields(2, 0, "R6");
    // R5 R6: embedded progressive with no vertical blanking
    setCfg(2, 2, 3, 3, 'h100, 0, 0, 4, 1, 0, 0);
    startRun();
    runFields(2, 0, "R5_R6");
    // R7: interlaced, alternating blanking pairs
    setCfg(3, 2, 1, 0, 1, 2, 1, 3, 2, 0, 0);
    startRun();
    runFields(4, 0, "R7");
    // R8: mid-frame reconfiguration
    setCfg(3, 2, 1, 2, 1, 1, 1, 0, 0, 0, 0);
    startRun();
    runFields(3, 1, "R8");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule